// File: doc/BRIEF.md
# Multibuffer SPI Transfer Sequencer

This block is an SPI master that works through lists of transfers kept in a shared entry RAM. Every RAM entry stands for one 16-bit transfer. Its transmit side holds the outgoing word and a chip-select hold bit. Its receive side holds the word captured from the bus, plus two flags that record whether the entry holds unread data and whether earlier unread data was overwritten.

Eight transfer groups split the RAM by means of a first and a last entry pointer. Each group chooses how it is started: by a software pulse, by the internal periodic tick, or by an external trigger pulse. A group can run its entries several times over, and it raises a DMA request every time a chosen entry finishes. This lets a small window of entries move a long payload. Only one group runs at a time, and the lowest-numbered pending group always goes next.

The controller is a five-state machine:
- ST_IDLE: chip select is high. When any group is pending, the machine grants one and moves to ST_FETCH.
- ST_FETCH: chip select goes low, the entry is read and the shifter starts. The machine moves to ST_XFER.
- ST_XFER: the machine waits for the shifter to finish, then moves to ST_STORE.
- ST_STORE: the machine writes back the received word and the flags, and raises the DMA request and the done pulse where they apply. It then does one of three things:
  - moves back to ST_FETCH when the entry's hold bit is set;
  - moves to ST_GAP when the hold bit is clear;
  - moves to ST_IDLE after the last entry of the last pass.
- ST_GAP: chip select is high for one cycle, then the machine moves to ST_FETCH.

Top module: `mbspi_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `dma_req`, `grp_done` and `grp_flag` are all zero, and reading any entry returns zero flags.
- R2: Each entry is sent as one 16-bit SPI mode-0 transfer, most significant bit first. The clock idles low, MOSI changes while the clock is low, and both sides sample on the rising edge. The word shifted in from MISO is stored in that entry's receive data.
- R3: If an entry's hold bit (`tx_hold`) is 1, chip select stays low into the next entry of the group. If the hold bit is 0, chip select goes high for at least one cycle between entries. Chip select always goes high when a group ends, and the clock is never high while chip select is high.
- R4: A granted group transfers entries from `grp_start` to `grp_end` inclusive, in increasing address order.
- R5: The 2-bit trigger select of each group works as follows:
  - 0: `soft_trig[g]` starts the group.
  - 1: the internal tick starts the group. The tick fires once every `TB_PERIOD` clock cycles.
  - 2: `ext_trig[g]` starts the group.
  - 3: nothing starts the group.
  A trigger from a source that is not selected, or any trigger while `grp_en[g]` is 0, has no effect.
- R6: When several groups are pending, the lowest-numbered one is served first. A running group is never interrupted.
- R7: Each time the entry at `grp_dma_ptr[g]` completes within group g, `dma_req[g]` pulses for one cycle.
- R8: A group runs its entry range `grp_reps[g]`+1 times before it completes.
- R9: A receive write sets the entry's fresh flag. If the fresh flag was already set, the write also sets the overrun flag. A read returns data, fresh and overrun one cycle after `rx_re` and clears both flags.
- R10: After the last entry of the last pass, `grp_done[g]` pulses for one cycle and `grp_flag[g]` is set. `grp_flag[g]` clears when group g is next granted.
- R11: A group with `grp_cont[g]` set becomes pending again as soon as it completes, for as long as it stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_we | input | 1 | Transmit entry write strobe |
| tx_addr | input | 7 | Transmit entry address |
| tx_hold | input | 1 | Chip-select hold bit for the entry |
| tx_data | input | 16 | Transmit word |
| rx_re | input | 1 | Receive entry read strobe |
| rx_addr | input | 7 | Receive entry address |
| rx_data | output | 16 | Received word, one cycle after read |
| rx_fresh | output | 1 | Entry held unread data |
| rx_ovr | output | 1 | Entry was overwritten while unread |
| grp_start | input | 56 | First entry per group, 7 bits each |
| grp_end | input | 56 | Last entry per group, 7 bits each |
| grp_dma_ptr | input | 56 | DMA entry per group, 7 bits each |
| grp_reps | input | 64 | Extra passes per group, 8 bits each |
| grp_trig | input | 16 | Trigger select per group, 2 bits each |
| grp_en | input | 8 | Group enables |
| grp_cont | input | 8 | Continuous mode per group |
| soft_trig | input | 8 | Software start pulses |
| ext_trig | input | 8 | External start pulses |
| dma_req | output | 8 | DMA request pulses |
| grp_done | output | 8 | Group completion pulses |
| grp_flag | output | 8 | Sticky group completion flags |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data out |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_miso | input | 1 | SPI data in |

## Verification
The assertions assume that each group's first pointer is not greater than its last pointer. They also assume that the configuration of the running group does not change while it runs. The bench configures a group only while that group is idle, and always gives a non-empty range.

A behavioural slave model in the bench supplies a numbered response word for each transfer. This lets received data be predicted exactly.

// File: rtl/mbspi_pkg.sv
package mbspi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_XFER,
        ST_STORE,
        ST_GAP
    } seq_state_t;

    localparam logic [1:0] TRG_SOFT = 2'd0;
    localparam logic [1:0] TRG_TICK = 2'd1;
    localparam logic [1:0] TRG_EXT  = 2'd2;
endpackage

// File: rtl/mbspi_tick.sv
module mbspi_tick #(
    parameter int TB_PERIOD = 1000,
    localparam int TW = (TB_PERIOD > 1) ? $clog2(TB_PERIOD) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt <= '0;
        else if (cnt == TW'(TB_PERIOD - 1))   cnt <= '0;
        else                                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == TW'(TB_PERIOD - 1));

    generate
        if (TB_PERIOD > 1) begin : g_spaced
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R5
        end
    endgenerate
endmodule

// File: rtl/mbspi_arb.sv
module mbspi_arb #(
    parameter int NGRP = 8,
    localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NGRP-1:0] req,
    output logic [GW-1:0]   gnt,
    output logic            any
);
    always_comb begin
        gnt = '0;
        for (int i = NGRP - 1; i >= 0; i--) begin
            if (req[i]) gnt = GW'(i);
        end
    end

    assign any = |req;

    AST_GNT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> req[gnt]); // R6
endmodule

// File: rtl/mbspi_shift.sv
module mbspi_shift #(
    parameter int DW = 16,
    localparam int CW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] din,
    input  logic          miso,
    output logic          sclk,
    output logic          mosi,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] sreg;
    logic [CW-1:0] cnt;
    logic          phase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg  <= '0;
            cnt   <= '0;
            phase <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b0;
            sclk  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                sreg  <= din;
                cnt   <= '0;
                phase <= 1'b0;
                busy  <= 1'b1;
                sclk  <= 1'b0;
            end else if (busy) begin
                if (!phase) begin
                    sclk  <= 1'b1;
                    phase <= 1'b1;
                end else begin
                    sclk  <= 1'b0;
                    phase <= 1'b0;
                    sreg  <= {sreg[DW-2:0], miso};
                    cnt   <= cnt + 1'b1;
                    if (cnt == CW'(DW - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end
        end
    end

    assign mosi = sreg[DW-1];
    assign dout = sreg;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_SCLK_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> busy); // R2
endmodule

// File: rtl/mbspi_seq.sv
module mbspi_seq
    import mbspi_pkg::*;
#(
    parameter int DEPTH     = 128,
    parameter int NGRP      = 8,
    parameter int DW        = 16,
    parameter int RW        = 8,
    parameter int TB_PERIOD = 1000,
    localparam int AW = $clog2(DEPTH),
    localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_we,
    input  logic [AW-1:0]      tx_addr,
    input  logic               tx_hold,
    input  logic [DW-1:0]      tx_data,
    input  logic               rx_re,
    input  logic [AW-1:0]      rx_addr,
    output logic [DW-1:0]      rx_data,
    output logic               rx_fresh,
    output logic               rx_ovr,
    input  logic [NGRP*AW-1:0] grp_start,
    input  logic [NGRP*AW-1:0] grp_end,
    input  logic [NGRP*AW-1:0] grp_dma_ptr,
    input  logic [NGRP*RW-1:0] grp_reps,
    input  logic [NGRP*2-1:0]  grp_trig,
    input  logic [NGRP-1:0]    grp_en,
    input  logic [NGRP-1:0]    grp_cont,
    input  logic [NGRP-1:0]    soft_trig,
    input  logic [NGRP-1:0]    ext_trig,
    output logic [NGRP-1:0]    dma_req,
    output logic [NGRP-1:0]    grp_done,
    output logic [NGRP-1:0]    grp_flag,
    output logic               spi_sclk,
    output logic               spi_mosi,
    output logic               spi_cs_n,
    input  logic               spi_miso
);
    seq_state_t     state;
    logic [GW-1:0]  cur;
    logic [AW-1:0]  ptr;
    logic [RW-1:0]  pass;
    logic           hold_r;
    logic [NGRP-1:0] pend, hit;
    logic [GW-1:0]  gnt;
    logic           any_pend, tick;
    logic           sh_busy, sh_done;
    logic [DW-1:0]  sh_dout;

    logic [DW:0]    txmem [DEPTH];
    logic [DW-1:0]  rxmem [DEPTH];
    logic [DEPTH-1:0] fresh_v, ovr_v;

    logic [AW-1:0] cur_start, cur_end, cur_dma;
    logic [RW-1:0] cur_reps;
    logic          last_entry, last_pass, store_done;

    assign cur_start  = grp_start[cur*AW +: AW];
    assign cur_end    = grp_end[cur*AW +: AW];
    assign cur_dma    = grp_dma_ptr[cur*AW +: AW];
    assign cur_reps   = grp_reps[cur*RW +: RW];
    assign last_entry = (ptr == cur_end);
    assign last_pass  = (pass == cur_reps);
    assign store_done = (state == ST_STORE) && last_entry && last_pass;

    mbspi_tick #(.TB_PERIOD(TB_PERIOD)) tick_i (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    mbspi_arb #(.NGRP(NGRP)) arb_i (
        .clk(clk), .rst_n(rst_n), .req(pend), .gnt(gnt), .any(any_pend)
    );

    mbspi_shift #(.DW(DW)) shift_i (
        .clk(clk), .rst_n(rst_n), .start(state == ST_FETCH),
        .din(txmem[ptr][DW-1:0]), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .busy(sh_busy),
        .done(sh_done), .dout(sh_dout)
    );

    // trigger decode
    always_comb begin
        for (int g = 0; g < NGRP; g++) begin
            unique case (grp_trig[g*2 +: 2])
                TRG_SOFT: hit[g] = grp_en[g] && soft_trig[g];
                TRG_TICK: hit[g] = grp_en[g] && tick;
                TRG_EXT:  hit[g] = grp_en[g] && ext_trig[g];
                default:  hit[g] = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            for (int g = 0; g < NGRP; g++) begin
                if (!grp_en[g])
                    pend[g] <= 1'b0;
                else if (hit[g] || (store_done && cur == GW'(g) && grp_cont[g]))
                    pend[g] <= 1'b1;
                else if (state == ST_IDLE && any_pend && gnt == GW'(g))
                    pend[g] <= 1'b0;
            end
        end
    end

    // state register and sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur    <= '0;
            ptr    <= '0;
            pass   <= '0;
            hold_r <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (any_pend) begin
                    cur   <= gnt;
                    ptr   <= grp_start[gnt*AW +: AW];
                    pass  <= '0;
                    state <= ST_FETCH;
                end
                ST_FETCH: begin
                    hold_r <= txmem[ptr][DW];
                    state  <= ST_XFER;
                end
                ST_XFER: if (sh_done) state <= ST_STORE;
                ST_STORE: begin
                    if (last_entry && last_pass) begin
                        state <= ST_IDLE;
                    end else begin
                        if (last_entry) begin
                            pass <= pass + 1'b1;
                            ptr  <= cur_start;
                        end else begin
                            ptr  <= ptr + 1'b1;
                        end
                        state <= hold_r ? ST_FETCH : ST_GAP;
                    end
                end
                ST_GAP:  state <= ST_FETCH;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign spi_cs_n = (state == ST_IDLE) || (state == ST_GAP);

    // outputs: event pulses and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_req  <= '0;
            grp_done <= '0;
            grp_flag <= '0;
        end else begin
            dma_req  <= '0;
            grp_done <= '0;
            if (state == ST_IDLE && any_pend) grp_flag[gnt] <= 1'b0;
            if (state == ST_STORE && ptr == cur_dma) dma_req[cur] <= 1'b1;
            if (store_done) begin
                grp_done[cur] <= 1'b1;
                grp_flag[cur] <= 1'b1;
            end
        end
    end

    // entry RAM
    always_ff @(posedge clk) begin
        if (tx_we) txmem[tx_addr] <= {tx_hold, tx_data};
        if (state == ST_STORE) rxmem[ptr] <= sh_dout;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh_v  <= '0;
            ovr_v    <= '0;
            rx_data  <= '0;
            rx_fresh <= 1'b0;
            rx_ovr   <= 1'b0;
        end else begin
            if (rx_re) begin
                rx_data           <= rxmem[rx_addr];
                rx_fresh          <= fresh_v[rx_addr];
                rx_ovr            <= ovr_v[rx_addr];
                fresh_v[rx_addr]  <= 1'b0;
                ovr_v[rx_addr]    <= 1'b0;
            end
            if (state == ST_STORE) begin
                fresh_v[ptr] <= 1'b1;
                ovr_v[ptr]   <= fresh_v[ptr];
            end
        end
    end

    AST_CLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R3
    AST_PTR_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (ptr >= cur_start && ptr <= cur_end)); // R4
    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(cur)); // R6
    AST_ONE_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dma_req)); // R7
    AST_PASS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (pass <= cur_reps)); // R8
    AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_done)); // R10
    AST_DONE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (|grp_done) |-> ((grp_done & grp_flag) == grp_done)); // R10
    AST_XFER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && $past(state) == ST_XFER) |-> (sh_busy || sh_done)); // R2
endmodule

// File: tb/mbspi_seq_tb_top.sv
`timescale 1ns/1ps
module mbspi_seq_tb_top;
    localparam int TBP = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        tx_we = 0, tx_hold = 0, rx_re = 0;
    logic [6:0]  tx_addr = '0, rx_addr = '0;
    logic [15:0] tx_data = '0, rx_data;
    logic        rx_fresh, rx_ovr;
    logic [55:0] v_start, v_end, v_dma;
    logic [63:0] v_reps;
    logic [15:0] v_trig;
    logic [7:0]  c_en = '0, c_cont = '0, s_trig = '0, e_trig = '0;
    logic [7:0]  dma_req, grp_done, grp_flag;
    logic        spi_sclk, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;

    logic [6:0] c_start [8];
    logic [6:0] c_end   [8];
    logic [6:0] c_dma   [8];
    logic [7:0] c_reps  [8];
    logic [1:0] c_trig  [8];

    always_comb begin
        for (int g = 0; g < 8; g++) begin
            v_start[g*7 +: 7] = c_start[g];
            v_end[g*7 +: 7]   = c_end[g];
            v_dma[g*7 +: 7]   = c_dma[g];
            v_reps[g*8 +: 8]  = c_reps[g];
            v_trig[g*2 +: 2]  = c_trig[g];
        end
    end

    mbspi_seq #(.TB_PERIOD(TBP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_we(tx_we), .tx_addr(tx_addr), .tx_hold(tx_hold), .tx_data(tx_data),
        .rx_re(rx_re), .rx_addr(rx_addr), .rx_data(rx_data),
        .rx_fresh(rx_fresh), .rx_ovr(rx_ovr),
        .grp_start(v_start), .grp_end(v_end), .grp_dma_ptr(v_dma),
        .grp_reps(v_reps), .grp_trig(v_trig), .grp_en(c_en), .grp_cont(c_cont),
        .soft_trig(s_trig), .ext_trig(e_trig),
        .dma_req(dma_req), .grp_done(grp_done), .grp_flag(grp_flag),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
        .spi_miso(spi_miso)
    );

    int n_chk = 0, n_err = 0;
    int cyc = 0;
    bit hold_tb [128];

    function automatic logic [15:0] txw(int i);
        return 16'(i * 259) ^ 16'h5A3C;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural SPI slave: records every word, answers C000 + word index
    logic [15:0] got_w [$];
    int          wcount = 0, frames = 0, bitc = 0;
    logic [15:0] cap = '0, sh = '0;

    always @(negedge spi_cs_n) begin
        if (rst_n) begin
            frames++;
            sh = 16'hC000 + 16'(wcount);
            spi_miso = sh[15];
        end
    end
    always @(posedge spi_sclk) begin
        cap = {cap[14:0], spi_mosi};
        bitc++;
        if (bitc == 16) begin
            got_w.push_back(cap);
            wcount++;
            bitc = 0;
        end
    end
    always @(negedge spi_sclk) begin
        if (bitc == 0) sh = 16'hC000 + 16'(wcount);
        else           sh = {sh[14:0], 1'b0};
        spi_miso = sh[15];
    end

    // per-clock monitor
    int dma_cnt [8];
    int done_cnt [8];
    int last_done [8];
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            for (int g = 0; g < 8; g++) begin
                if (dma_req[g]) dma_cnt[g]++;
                if (grp_done[g]) begin
                    done_cnt[g]++;
                    last_done[g] = cyc;
                end
            end
            if (spi_cs_n && spi_sclk) begin
                n_chk++;
                n_err++;
                $display("FAIL R3 clock high with cs released actual=1 expected=0");
            end
        end
        if (cyc == 150000) begin
            n_err++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic pulse_soft(input int g);
        @(negedge clk); s_trig[g] = 1'b1;
        @(negedge clk); s_trig[g] = 1'b0;
    endtask

    task automatic pulse_ext(input int g);
        @(negedge clk); e_trig[g] = 1'b1;
        @(negedge clk); e_trig[g] = 1'b0;
    endtask

    task automatic wait_done(input int g, input int target, input string tag);
        int n = 0;
        while (done_cnt[g] < target && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done_cnt[g] >= target, tag, done_cnt[g], target);
    endtask

    task automatic rd(input int a);
        @(negedge clk); rx_re = 1'b1; rx_addr = 7'(a);
        @(negedge clk); rx_re = 1'b0;
    endtask

    int exp_e [$];
    task automatic cmp_words(input string tag, input int base);
        chk(got_w.size() == base + exp_e.size(), tag, got_w.size() - base, exp_e.size());
        foreach (exp_e[k]) begin
            if (base + k < got_w.size())
                chk(got_w[base + k] == txw(exp_e[k]), tag, got_w[base + k], txw(exp_e[k]));
        end
        exp_e.delete();
    endtask

    initial begin
        int base, fr0, t1;
        for (int g = 0; g < 8; g++) begin
            c_start[g] = '0; c_end[g] = '0; c_dma[g] = 7'd127;
            c_reps[g] = '0;  c_trig[g] = 2'd3;
            dma_cnt[g] = 0;  done_cnt[g] = 0; last_done[g] = 0;
        end
        for (int i = 0; i < 128; i++) hold_tb[i] = 1'b0;
        hold_tb[2] = 1'b1; hold_tb[4] = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R1 sclk", spi_sclk, 0);
        chk(dma_req == 8'h00 && grp_done == 8'h00, "R1 pulses", {dma_req, grp_done}, 0);
        chk(grp_flag == 8'h00, "R1 flags", grp_flag, 0);
        rd(5);
        chk(rx_fresh == 0 && rx_ovr == 0, "R1 rx flags", {rx_fresh, rx_ovr}, 0);

        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            tx_we = 1'b1; tx_addr = 7'(i); tx_data = txw(i); tx_hold = hold_tb[i];
        end
        @(negedge clk); tx_we = 1'b0;

        // R2 R3 R4 R9 R10: group 0 over entries 2..4, hold on 2 only matters
        c_start[0] = 7'd2; c_end[0] = 7'd4; c_trig[0] = 2'd0; c_en[0] = 1'b1;
        base = got_w.size(); fr0 = frames;
        pulse_soft(0);
        wait_done(0, 1, "R10 group0 done");
        repeat (3) @(negedge clk);
        exp_e = '{2, 3, 4};
        cmp_words("R2 R4 group0 words", base);
        chk(frames - fr0 == 2, "R3 frame count", frames - fr0, 2);
        chk(spi_cs_n == 1'b1, "R3 cs released at end", spi_cs_n, 1);
        chk(grp_flag[0] == 1'b1, "R10 sticky flag", grp_flag[0], 1);
        for (int k = 0; k < 3; k++) begin
            rd(2 + k);
            chk(rx_data == 16'hC000 + 16'(base + k), "R2 rx data", rx_data, 16'hC000 + base + k);
            chk(rx_fresh == 1 && rx_ovr == 0, "R9 fresh after write", {rx_fresh, rx_ovr}, 2);
        end
        rd(2);
        chk(rx_fresh == 0, "R9 read clears fresh", rx_fresh, 0);

        // R7 R8 R9: group 1, entries 10..11, three passes, DMA on 11
        c_start[1] = 7'd10; c_end[1] = 7'd11; c_reps[1] = 8'd2; c_dma[1] = 7'd11;
        c_trig[1] = 2'd0; c_en[1] = 1'b1;
        base = got_w.size(); fr0 = frames;
        pulse_soft(1);
        wait_done(1, 1, "R8 group1 done");
        repeat (3) @(negedge clk);
        exp_e = '{10, 11, 10, 11, 10, 11};
        cmp_words("R8 repeated passes", base);
        chk(dma_cnt[1] == 3, "R7 dma pulses", dma_cnt[1], 3);
        chk(frames - fr0 == 6, "R3 no hold toggles cs", frames - fr0, 6);
        rd(11);
        chk(rx_data == 16'hC000 + 16'(base + 5), "R2 last rx data", rx_data, 16'hC000 + base + 5);
        chk(rx_ovr == 1'b1, "R9 overrun", rx_ovr, 1);

        // R10 flag clears on new start
        pulse_soft(1);
        while (spi_cs_n) @(negedge clk);
        chk(grp_flag[1] == 1'b0, "R10 flag cleared on start", grp_flag[1], 0);
        wait_done(1, 2, "R10 group1 rerun");
        repeat (3) @(negedge clk);
        chk(grp_flag[1] == 1'b1, "R10 flag set again", grp_flag[1], 1);

        // R6 priority and no preemption
        c_start[2] = 7'd20; c_end[2] = 7'd20; c_trig[2] = 2'd0; c_en[2] = 1'b1;
        c_start[3] = 7'd21; c_end[3] = 7'd22; c_trig[3] = 2'd0; c_en[3] = 1'b1;
        base = got_w.size();
        @(negedge clk); s_trig = 8'b0000_1100;
        @(negedge clk); s_trig = 8'h00;
        repeat (6) @(negedge clk);
        pulse_soft(0);
        wait_done(3, 1, "R6 group3 done");
        repeat (3) @(negedge clk);
        exp_e = '{20, 2, 3, 4, 21, 22};
        cmp_words("R6 service order", base);

        // R5 disabled and mismatched triggers
        c_start[4] = 7'd30; c_end[4] = 7'd30; c_trig[4] = 2'd2; c_en[4] = 1'b1;
        c_start[5] = 7'd31; c_end[5] = 7'd31; c_trig[5] = 2'd2; c_en[5] = 1'b0;
        base = got_w.size();
        pulse_ext(5);
        repeat (80) @(negedge clk);
        chk(got_w.size() == base && done_cnt[5] == 0, "R5 disabled group idle", got_w.size() - base, 0);
        pulse_soft(4);
        repeat (80) @(negedge clk);
        chk(got_w.size() == base && done_cnt[4] == 0, "R5 wrong source ignored", got_w.size() - base, 0);
        pulse_ext(4);
        wait_done(4, 1, "R5 external start");
        repeat (3) @(negedge clk);
        exp_e = '{30};
        cmp_words("R5 external words", base);

        // R5 periodic tick
        c_start[6] = 7'd40; c_end[6] = 7'd40; c_trig[6] = 2'd1; c_en[6] = 1'b1;
        wait_done(6, 1, "R5 tick start");
        t1 = last_done[6];
        wait_done(6, 2, "R5 tick repeat");
        chk(last_done[6] - t1 == TBP, "R5 tick spacing", last_done[6] - t1, TBP);
        c_en[6] = 1'b0;
        repeat (TBP + 60) @(negedge clk);
        chk(done_cnt[6] == 2, "R5 disabled tick ignored", done_cnt[6], 2);

        // R11 continuous mode
        c_start[7] = 7'd50; c_end[7] = 7'd51; c_trig[7] = 2'd0;
        c_en[7] = 1'b1; c_cont[7] = 1'b1;
        base = got_w.size();
        pulse_soft(7);
        wait_done(7, 3, "R11 continuous reruns");
        c_en[7] = 1'b0;
        repeat (120) @(negedge clk);
        t1 = done_cnt[7];
        repeat (200) @(negedge clk);
        chk(done_cnt[7] == t1, "R11 stops when disabled", done_cnt[7], t1);
        chk(got_w[base] == txw(50) && got_w[base + 3] == txw(51), "R11 words", got_w[base + 3], txw(51));
        chk(done_cnt[0] == 2, "R11 one-shot group not rerun", done_cnt[0], 2);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule